// File: doc/BRIEF.md
# Load Queue with Snoop-Triggered Replay

This block tracks in-flight loads of an out-of-order core in a circular queue. Each load takes a slot when it is dispatched. The slot gets an age tag from a running sequence counter. Later, the core reports the load's physical line address (the load is then issued) and its returned data (the load is then complete). Data may arrive in any order. Retirement happens strictly at the head of the queue, and only once the head load has its data.

A completed load that has not yet retired stays visible to the coherence side. When an invalidation snoop names the line of such a load, the value that load returned may be stale. The block then raises a one-cycle squash request. The request carries the age and slot of the oldest offending load. In the same edge, the block frees that slot and every younger slot, so the core can refetch and re-execute from that load onward. Loads that have not completed ignore snoops, because they will read fresh data when they execute. Cache access, store forwarding and the pipeline flush itself belong to neighbouring blocks.

Top module: `ldq_snoop_replay`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `alloc_ready_o`=1, `alloc_idx_o`=0, `alloc_age_o`=0, and `squash_vld_o` and `retire_vld_o` are 0.
- R2: Each accepted allocation takes the slot shown on `alloc_idx_o` and the age shown on `alloc_age_o`. The slot advances by one modulo DEPTH and the age advances by one modulo 2^AGE_W.
- R3: With DEPTH unretired loads, `full_o`=1 and `alloc_ready_o`=0. An allocation request while full changes neither `alloc_idx_o` nor `alloc_age_o`.
- R4: `head_done_o` is 1 only when the head load has received its data. `retire_i` has no effect while `head_done_o` is 0. Otherwise, one cycle after `retire_i`, `retire_vld_o` pulses with the head's data and age.
- R5: Loads may complete out of program order. Data is kept per slot and returned at retirement in allocation order. Data for a slot is accepted only after its address has been given.
- R6: A snoop whose line address equals the stored line of a completed, unretired load raises `squash_vld_o` on the next cycle, with that load's age and slot. The line address is the physical address with its low 6 bits (the 64-byte offset) removed.
- R7: A snoop has no effect on loads that are issued but not complete, and no effect when its line matches no stored line.
- R8: When several completed loads match one snoop, the squash reports the oldest of them in program order.
- R9: A squash frees the offending slot and every younger slot. It rewinds `alloc_idx_o` and `alloc_age_o` to the offending slot and age. Older loads stay queued and can still retire.
- R10: A head load that retires in the same cycle as a matching snoop retires and is not squashed. An allocation in a squash cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Request a slot for a new load |
| alloc_ready_o | output | 1 | Queue can accept an allocation |
| alloc_idx_o | output | IDXW | Slot the next allocation takes |
| alloc_age_o | output | AGE_W | Age the next allocation takes |
| addr_vld_i | input | 1 | Physical line address available |
| addr_idx_i | input | IDXW | Slot receiving the address |
| addr_line_i | input | LINE_W | Physical line address of the load |
| data_vld_i | input | 1 | Load data returned |
| data_idx_i | input | IDXW | Slot receiving the data |
| data_i | input | DATA_W | Returned load data |
| retire_i | input | 1 | Retire the head load |
| head_done_o | output | 1 | Head load has its data |
| retire_vld_o | output | 1 | A load retired on the previous edge |
| retire_data_o | output | DATA_W | Data of the retired load |
| retire_age_o | output | AGE_W | Age of the retired load |
| snoop_vld_i | input | 1 | Invalidation snoop present |
| snoop_line_i | input | LINE_W | Line address being invalidated |
| squash_vld_o | output | 1 | Memory-order violation detected |
| squash_age_o | output | AGE_W | Age of the oldest offending load |
| squash_idx_o | output | IDXW | Slot of the oldest offending load |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
Retirement and snoop detection share a cycle whenever the snoop hits the head load as the core retires it. The bench drives `retire_i` and a matching `snoop_vld_i` together on a queue of two completed loads with the same line. It expects a retire pulse with age 0 and a squash naming age 1. The queue then ends up empty, with the allocation pointer at slot 1. Allocation and squash also collide. In that case the bench asserts `alloc_i` during a hitting snoop, then checks that the pointer and age land on the offender rather than one past it.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  // Per-slot status: slot in use, address known, data returned.
  typedef struct packed {
    logic busy;
    logic issued;
    logic done;
  } ldq_flags_t;

endpackage

// File: rtl/ldq_line_cmp.sv
// Per-slot comparison of stored line addresses against a snoop line.
module ldq_line_cmp #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic [DEPTH-1:0][LINE_W-1:0] line_tab,
  input  logic [DEPTH-1:0]             watch,
  input  logic [LINE_W-1:0]            probe,
  output logic [DEPTH-1:0]             hit
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = watch[g] && (line_tab[g] == probe);
  end

endmodule

// File: rtl/ldq_oldest_pick.sv
// Finds the lowest set bit of a request vector already rotated to head order.
module ldq_oldest_pick #(
  parameter int N = 8,
  localparam int OW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [OW-1:0] off
);

  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        off   = OW'(i);
      end
    end
  end

endmodule

// File: rtl/ldq_snoop_replay.sv
module ldq_snoop_replay
  import ldq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PA_W     = 32,
  parameter int LINE_OFF = 6,
  parameter int DATA_W   = 32,
  parameter int AGE_W    = 6,
  localparam int IDXW    = $clog2(DEPTH),
  localparam int PTRW    = IDXW + 1,
  localparam int LINE_W  = PA_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  output logic              alloc_ready_o,
  output logic [IDXW-1:0]   alloc_idx_o,
  output logic [AGE_W-1:0]  alloc_age_o,
  input  logic              addr_vld_i,
  input  logic [IDXW-1:0]   addr_idx_i,
  input  logic [LINE_W-1:0] addr_line_i,
  input  logic              data_vld_i,
  input  logic [IDXW-1:0]   data_idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              retire_i,
  output logic              head_done_o,
  output logic              retire_vld_o,
  output logic [DATA_W-1:0] retire_data_o,
  output logic [AGE_W-1:0]  retire_age_o,
  input  logic              snoop_vld_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output logic              squash_vld_o,
  output logic [AGE_W-1:0]  squash_age_o,
  output logic [IDXW-1:0]   squash_idx_o,
  output logic              full_o,
  output logic              empty_o
);

  ldq_flags_t              flags_q [DEPTH];
  logic [DEPTH-1:0][LINE_W-1:0] line_q;
  logic [AGE_W-1:0]        age_q   [DEPTH];
  logic [DATA_W-1:0]       dmem    [DEPTH];
  logic [PTRW-1:0]         head_q, tail_q;
  logic [AGE_W-1:0]        seq_q;

  logic [IDXW-1:0] head_idx;
  logic [PTRW-1:0] count_q;
  assign head_idx = head_q[IDXW-1:0];
  assign count_q  = tail_q - head_q;

  assign alloc_ready_o = !full_o;
  assign alloc_idx_o   = tail_q[IDXW-1:0];
  assign alloc_age_o   = seq_q;
  assign head_done_o   = flags_q[head_idx].busy && flags_q[head_idx].done;

  logic retire_fire;
  assign retire_fire = retire_i && head_done_o;

  // Completed loads still in the queue are exposed to snoops.
  logic [DEPTH-1:0] watch, hit_abs, hit_rel;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      watch[i] = flags_q[i].busy && flags_q[i].done;
    end
  end

  ldq_line_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) cmp_i (
    .line_tab (line_q),
    .watch    (watch),
    .probe    (snoop_line_i),
    .hit      (hit_abs)
  );

  // Rotate to head order; a head retiring this cycle is out of reach.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_rel[i] = hit_abs[head_idx + IDXW'(i)];
    end
    if (retire_fire) hit_rel[0] = 1'b0;
  end

  logic            found;
  logic [IDXW-1:0] hit_off;
  ldq_oldest_pick #(.N(DEPTH)) pick_i (
    .req   (hit_rel),
    .found (found),
    .off   (hit_off)
  );

  logic            squash_hit;
  logic [IDXW-1:0] bad_slot;
  assign squash_hit = snoop_vld_i && found;
  assign bad_slot   = head_idx + hit_off;

  logic alloc_fire;
  assign alloc_fire = alloc_i && !full_o && !squash_hit;

  logic [PTRW-1:0]  head_n, tail_n, cnt_n;
  logic [AGE_W-1:0] seq_n;
  always_comb begin
    head_n = head_q + PTRW'(retire_fire);
    if (squash_hit) begin
      tail_n = head_q + PTRW'(hit_off);
      seq_n  = age_q[bad_slot];
    end else begin
      tail_n = tail_q + PTRW'(alloc_fire);
      seq_n  = seq_q + AGE_W'(alloc_fire);
    end
    cnt_n = tail_n - head_n;
  end

  // Slots from the offender up to the tail are released on a squash.
  logic [DEPTH-1:0] kill;
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      kill[j] = squash_hit
             && ((IDXW'(j) - head_idx) >= hit_off)
             && (PTRW'(IDXW'(j) - head_idx) < count_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q        <= '0;
      tail_q        <= '0;
      seq_q         <= '0;
      full_o        <= 1'b0;
      empty_o       <= 1'b1;
      retire_vld_o  <= 1'b0;
      retire_data_o <= '0;
      retire_age_o  <= '0;
      squash_vld_o  <= 1'b0;
      squash_age_o  <= '0;
      squash_idx_o  <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        flags_q[j] <= '0;
        age_q[j]   <= '0;
        line_q[j]  <= '0;
      end
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      seq_q   <= seq_n;
      full_o  <= (cnt_n == PTRW'(DEPTH));
      empty_o <= (cnt_n == '0);

      retire_vld_o <= retire_fire;
      if (retire_fire) begin
        retire_data_o <= dmem[head_idx];
        retire_age_o  <= age_q[head_idx];
      end

      squash_vld_o <= squash_hit;
      if (squash_hit) begin
        squash_age_o <= age_q[bad_slot];
        squash_idx_o <= bad_slot;
      end

      if (addr_vld_i && flags_q[addr_idx_i].busy) begin
        line_q[addr_idx_i]         <= addr_line_i;
        flags_q[addr_idx_i].issued <= 1'b1;
      end
      if (data_vld_i && flags_q[data_idx_i].busy && flags_q[data_idx_i].issued) begin
        flags_q[data_idx_i].done <= 1'b1;
      end
      if (alloc_fire) begin
        flags_q[tail_q[IDXW-1:0]] <= '{busy: 1'b1, issued: 1'b0, done: 1'b0};
        age_q[tail_q[IDXW-1:0]]   <= seq_q;
      end
      if (retire_fire) begin
        flags_q[head_idx] <= '0;
      end
      for (int j = 0; j < DEPTH; j++) begin
        if (kill[j]) flags_q[j] <= '0;
      end
    end
  end

  // Data storage without reset, one write port.
  always_ff @(posedge clk) begin
    if (data_vld_i) dmem[data_idx_i] <= data_i;
  end

  // R1/R3: the two occupancy flags never hold together.
  a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o));

  // R3: a full queue without a squash keeps its allocation age.
  a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (rst)
    (full_o && !squash_hit) |=> (alloc_age_o == $past(alloc_age_o)));

  // R4: a retire request on a head without data yields no retirement.
  a_r4_retire_needs_data: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !head_done_o) |=> !retire_vld_o);

  // R4: an empty queue has no completed head.
  a_r4_empty_no_head: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> !head_done_o);

  // R7: nothing in the queue, nothing to squash.
  a_r7_empty_no_squash: assert property (@(posedge clk) disable iff (rst)
    (empty_o && snoop_vld_i) |=> !squash_vld_o);

  // R9: the allocation pointer lands on the reported offender.
  a_r9_rewind_to_offender: assert property (@(posedge clk) disable iff (rst)
    squash_vld_o |-> (alloc_age_o == squash_age_o && alloc_idx_o == squash_idx_o));

endmodule

// File: tb/ldq_snoop_replay_tb_top.sv
module ldq_snoop_replay_tb_top;

  localparam int DEPTH  = 8;
  localparam int IDXW   = 3;
  localparam int LINE_W = 26;
  localparam int DATA_W = 32;
  localparam int AGE_W  = 6;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic              alloc_i, alloc_ready_o;
  logic [IDXW-1:0]   alloc_idx_o;
  logic [AGE_W-1:0]  alloc_age_o;
  logic              addr_vld_i;
  logic [IDXW-1:0]   addr_idx_i;
  logic [LINE_W-1:0] addr_line_i;
  logic              data_vld_i;
  logic [IDXW-1:0]   data_idx_i;
  logic [DATA_W-1:0] data_i;
  logic              retire_i, head_done_o, retire_vld_o;
  logic [DATA_W-1:0] retire_data_o;
  logic [AGE_W-1:0]  retire_age_o;
  logic              snoop_vld_i;
  logic [LINE_W-1:0] snoop_line_i;
  logic              squash_vld_o;
  logic [AGE_W-1:0]  squash_age_o;
  logic [IDXW-1:0]   squash_idx_o;
  logic              full_o, empty_o;

  ldq_snoop_replay dut_i (
    .clk(clk), .rst(rst),
    .alloc_i(alloc_i), .alloc_ready_o(alloc_ready_o),
    .alloc_idx_o(alloc_idx_o), .alloc_age_o(alloc_age_o),
    .addr_vld_i(addr_vld_i), .addr_idx_i(addr_idx_i), .addr_line_i(addr_line_i),
    .data_vld_i(data_vld_i), .data_idx_i(data_idx_i), .data_i(data_i),
    .retire_i(retire_i), .head_done_o(head_done_o),
    .retire_vld_o(retire_vld_o), .retire_data_o(retire_data_o),
    .retire_age_o(retire_age_o),
    .snoop_vld_i(snoop_vld_i), .snoop_line_i(snoop_line_i),
    .squash_vld_o(squash_vld_o), .squash_age_o(squash_age_o),
    .squash_idx_o(squash_idx_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [DATA_W-1:0] data;
    logic [IDXW-1:0]   slot;   // completion order: slot finishing at step i
  } vec_t;

  localparam vec_t VEC [DEPTH] = '{
    '{26'h0000011, 32'hA000_0001, 3'd3},
    '{26'h0000022, 32'hB000_0002, 3'd0},
    '{26'h0000033, 32'hC000_0003, 3'd7},
    '{26'h0000044, 32'hD000_0004, 3'd1},
    '{26'h0000055, 32'hE000_0005, 3'd5},
    '{26'h0000066, 32'hF000_0006, 3'd2},
    '{26'h0000077, 32'h1234_5678, 3'd6},
    '{26'h0000088, 32'h8765_4321, 3'd4}
  };

  int n_run  = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    alloc_i = 0; addr_vld_i = 0; data_vld_i = 0; retire_i = 0; snoop_vld_i = 0;
    addr_idx_i = '0; addr_line_i = '0; data_idx_i = '0; data_i = '0; snoop_line_i = '0;
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    tick(); tick();
    rst = 0;
  endtask

  task automatic alloc1();
    alloc_i = 1; tick(); alloc_i = 0;
  endtask

  task automatic addr1(input logic [IDXW-1:0] s, input logic [LINE_W-1:0] l);
    addr_vld_i = 1; addr_idx_i = s; addr_line_i = l; tick(); addr_vld_i = 0;
  endtask

  task automatic data1(input logic [IDXW-1:0] s, input logic [DATA_W-1:0] d);
    data_vld_i = 1; data_idx_i = s; data_i = d; tick(); data_vld_i = 0;
  endtask

  task automatic snoop1(input logic [LINE_W-1:0] l);
    snoop_vld_i = 1; snoop_line_i = l; tick(); snoop_vld_i = 0;
  endtask

  task automatic run_all();
    // ---- R1: reset state
    do_reset();
    check("R1 empty", empty_o, 1);
    check("R1 full", full_o, 0);
    check("R1 ready", alloc_ready_o, 1);
    check("R1 idx", alloc_idx_o, 0);
    check("R1 age", alloc_age_o, 0);
    check("R1 squash", squash_vld_o, 0);
    check("R1 retire", retire_vld_o, 0);

    // ---- vector walk: fill, complete out of order, retire in order
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 slot", alloc_idx_o, i);
      check("R2 age", alloc_age_o, i);
      alloc1();
    end
    check("R3 full", full_o, 1);
    check("R3 ready low", alloc_ready_o, 0);
    alloc1();
    check("R3 age held", alloc_age_o, 8);
    check("R3 still full", full_o, 1);
    for (int i = 0; i < DEPTH; i++) addr1(IDXW'(i), VEC[i].line);
    check("R4 head not done", head_done_o, 0);
    retire_i = 1; tick(); retire_i = 0;
    check("R4 no retire", retire_vld_o, 0);
    check("R4 still full", full_o, 1);
    for (int i = 0; i < DEPTH; i++) data1(VEC[i].slot, VEC[VEC[i].slot].data);
    check("R4 head done", head_done_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      retire_i = 1; tick(); retire_i = 0;
      check("R4 retire pulse", retire_vld_o, 1);
      check("R5 retire data", retire_data_o, VEC[i].data);
      check("R5 retire age", retire_age_o, i);
    end
    check("R5 empty after", empty_o, 1);
    check("R2 wrap slot", alloc_idx_o, 0);
    check("R2 wrap age", alloc_age_o, 8);

    // ---- snoop filtering and oldest selection
    do_reset();
    for (int i = 0; i < 4; i++) alloc1();
    addr1(3'd0, 26'h0AAAAAA);
    addr1(3'd1, 26'h0400001);
    addr1(3'd2, 26'h0400001);
    addr1(3'd3, 26'h0CCCCCC);
    data1(3'd3, 32'h33);
    data1(3'd2, 32'h22);
    data1(3'd1, 32'h11);
    snoop1(26'h0AAAAAA);
    check("R7 incomplete ignores", squash_vld_o, 0);
    snoop1(26'h0DDDDDD);
    check("R7 no line match", squash_vld_o, 0);
    check("R7 tail kept", alloc_idx_o, 4);
    snoop1(26'h0400001);
    check("R6 squash raised", squash_vld_o, 1);
    check("R8 oldest age", squash_age_o, 1);
    check("R8 oldest slot", squash_idx_o, 1);
    check("R9 rewind slot", alloc_idx_o, 1);
    check("R9 rewind age", alloc_age_o, 1);
    check("R9 older kept", empty_o, 0);
    tick();
    check("R6 squash one cycle", squash_vld_o, 0);
    data1(3'd0, 32'h5A5A_0000);
    retire_i = 1; tick(); retire_i = 0;
    check("R9 older retires", retire_data_o, 32'h5A5A_0000);
    check("R9 empty after", empty_o, 1);

    // ---- R6 single match on a later slot
    do_reset();
    alloc1(); alloc1();
    addr1(3'd0, 26'h0000100); addr1(3'd1, 26'h0000200);
    data1(3'd0, 32'h1); data1(3'd1, 32'h2);
    snoop1(26'h0000200);
    check("R6 single age", squash_age_o, 1);
    check("R6 single slot", squash_idx_o, 1);

    // ---- R10: retire and matching snoop together
    do_reset();
    alloc1(); alloc1();
    addr1(3'd0, 26'h0000E0E); addr1(3'd1, 26'h0000E0E);
    data1(3'd0, 32'hAB); data1(3'd1, 32'hCD);
    retire_i = 1; snoop_vld_i = 1; snoop_line_i = 26'h0000E0E;
    tick();
    retire_i = 0; snoop_vld_i = 0;
    check("R10 retire happened", retire_vld_o, 1);
    check("R10 retire age", retire_age_o, 0);
    check("R10 squash younger", squash_age_o, 1);
    check("R10 squash vld", squash_vld_o, 1);
    check("R10 empty", empty_o, 1);
    check("R10 slot", alloc_idx_o, 1);

    // ---- R10: allocation during squash is dropped
    do_reset();
    alloc1();
    addr1(3'd0, 26'h0000F0F);
    data1(3'd0, 32'h77);
    alloc_i = 1; snoop_vld_i = 1; snoop_line_i = 26'h0000F0F;
    tick();
    alloc_i = 0; snoop_vld_i = 0;
    check("R10 squash head", squash_age_o, 0);
    check("R10 alloc dropped idx", alloc_idx_o, 0);
    check("R10 alloc dropped age", alloc_age_o, 0);
    check("R10 empty after drop", empty_o, 1);
  endtask

  initial begin
    rst = 1;
    idle();
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule